// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Level Interrupts

This block is the data-buffering core of an SPI controller. It holds two byte queues: a transmit queue, filled by the bus side and emptied by the serial shift engine, and a receive queue, filled by the shift engine and emptied by the bus side. Each queue reports its occupancy. The two counts are packed into one status word, so software can see how much room or data is present.

On top of the queues sits an interrupt unit with three sources. The first is a receive-nearly-full level, raised when at least three quarters of the receive queue is in use. The second is a transmit-nearly-empty level, raised when at most one quarter of the transmit queue is in use. The third is a transfer-done event that the shift engine pulses. Each source has a sticky status bit, cleared by writing one, and an enable bit at the same position. A single interrupt line is the OR of the enabled status bits. Each queue also has its own flush control, which empties it at once.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue holds 64 bytes, and its occupancy count runs from 0 to 64.
- R2: Each queue returns bytes in the order they were pushed. Transmit bytes enter through the bus write port and leave through the engine read port. Receive bytes enter through the engine write port and leave through the bus read port. Popped data appears on the read data output in the cycle after the pop.
- R3: The status word carries the receive count in bits 6:0 and the transmit count in bits 22:16. Every other bit of the word reads 0.
- R4: Status bit 4 (receive nearly full) becomes 1 in the cycle after the receive count is 48 or more. It stays 0 while the count is 47 or less and the bit has been cleared.
- R5: Status bit 12 (transmit nearly empty) becomes 1 in the cycle after the transmit count is 16 or less. It stays 0 at 17 or more once cleared.
- R6: Writing 1 to a status bit clears it. A level bit whose condition still holds reads 0 for one cycle after the clear and 1 again in the following cycle. Writing 0 to a status bit leaves it unchanged.
- R7: A transfer-done pulse sets status bit 16, and the bit stays set until it is cleared. A pulse in the same cycle as a clear of bit 16 leaves the bit set.
- R8: A flush empties its queue in one cycle. The flush wins over a push or pop in the same cycle.
- R9: A push to a full queue is ignored and leaves the count and contents unchanged. A pop from an empty queue is ignored and returns 0.
- R10: The enable register holds bits 4, 12 and 16, and all its other bits read 0. The interrupt output is 1 exactly when some status bit and its enable bit are both 1, in the same cycle as those bits.
- R11: After reset both queues are empty, and the status, enable and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Bus write of one transmit byte |
| tx_push_data | input | 8 | Transmit byte to store |
| tx_pop | input | 1 | Shift engine takes one transmit byte |
| tx_pop_data | output | 8 | Transmit byte taken, valid the cycle after tx_pop |
| rx_push | input | 1 | Shift engine stores one received byte |
| rx_push_data | input | 8 | Received byte to store |
| rx_pop | input | 1 | Bus read of one received byte |
| rx_pop_data | output | 8 | Received byte read, valid the cycle after rx_pop |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| xfer_done | input | 1 | One-cycle transfer-complete pulse from the shift engine |
| irq_en_wr | input | 1 | Write strobe for the enable register |
| irq_en_wdata | input | 32 | New enable register value |
| irq_clr_wr | input | 1 | Write strobe for the write-one-to-clear status register |
| irq_clr_wdata | input | 32 | Mask of status bits to clear |
| irq_en | output | 32 | Current enable register |
| irq_status | output | 32 | Current status register |
| fifo_level | output | 32 | Packed occupancy counts |
| irq | output | 1 | Combined interrupt line |

## Verification
Inputs change just after a falling edge and outputs are sampled at the next falling edge. A push, pop, flush or register write is therefore visible one edge after it is driven. Popped data is checked one edge after the pop against a scoreboard queue that the push tasks fill. A threshold bit lags the count that triggers it by one more edge, so the bench checks it twice: at the edge where the count crosses, when the bit must still be 0, and at the next edge, when it must be 1. The re-set after a clear is tested the same way. The interrupt line is checked at the same sample as the status and enable bits that drive it.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_W       = 32;
  localparam int POS_RX_HI   = 4;
  localparam int POS_TX_LO   = 12;
  localparam int POS_DONE    = 16;
  localparam int LVL_RX_LSB  = 0;
  localparam int LVL_TX_LSB  = 16;
  localparam int NUM_SRC     = 3;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign do_push = push && (count != FULL_CNT) && !flush;
  assign do_pop  = pop  && (count != '0) && !flush;

  // storage: write port only, no reset, so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= do_pop ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R8: flush leaves the queue empty
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0);

  // R9: push into a full queue without pop leaves it full
  p_full_push_r9: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && push && !pop && !flush) |=> count == FULL_CNT);

  // R9: pop from an empty queue returns zero
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && pop) |=> pop_data == '0);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int RX_HI_MIN = (DEPTH * 3) / 4,
  localparam int TX_LO_MAX = DEPTH / 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    rx_count,
  input  logic [CW-1:0]    tx_count,
  input  logic             xfer_done,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] clr_wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] sta_q,
  output logic             irq
);
  localparam int SRC_POS [NUM_SRC] = '{POS_RX_HI, POS_TX_LO, POS_DONE};

  logic [NUM_SRC-1:0] en_r, sta_r, en_n, sta_n, src;

  assign src[0] = (rx_count >= CW'(RX_HI_MIN));
  assign src[1] = (tx_count <= CW'(TX_LO_MAX));
  assign src[2] = xfer_done;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic clr_hit;
    assign clr_hit = clr_wr && clr_wdata[SRC_POS[k]];
    assign en_n[k] = en_wr ? en_wdata[SRC_POS[k]] : en_r[k];
    if (k == 2) begin : g_event
      // an event arriving with a clear is kept
      assign sta_n[k] = (sta_r[k] && !clr_hit) || src[k];
    end else begin : g_level
      // a clear wins for one cycle; the level re-sets it afterwards
      assign sta_n[k] = clr_hit ? 1'b0 : (sta_r[k] || src[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r  <= '0;
      sta_r <= '0;
      irq   <= 1'b0;
    end else begin
      en_r  <= en_n;
      sta_r <= sta_n;
      irq   <= |(sta_n & en_n);
    end
  end

  always_comb begin
    en_q  = '0;
    sta_q = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      en_q[SRC_POS[k]]  = en_r[k];
      sta_q[SRC_POS[k]] = sta_r[k];
    end
  end

  // R4: receive level sets its bit on the next cycle
  p_rx_level_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_count >= CW'(RX_HI_MIN) && !(clr_wr && clr_wdata[POS_RX_HI]))
      |=> sta_q[POS_RX_HI]);

  // R5: transmit level sets its bit on the next cycle
  p_tx_level_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CW'(TX_LO_MAX) && !(clr_wr && clr_wdata[POS_TX_LO]))
      |=> sta_q[POS_TX_LO]);

  // R6: clearing a level bit drops it for a cycle
  p_w1c_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_wdata[POS_RX_HI]) |=> !sta_q[POS_RX_HI]);

  // R7: a done pulse always leaves the bit set
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> sta_q[POS_DONE]);

  // R10: line matches enabled status bits
  p_irq_line_r10: assert property (@(posedge clk) disable iff (rst)
    irq == (|(sta_q & en_q)));
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              xfer_done,
  input  logic              irq_en_wr,
  input  logic [REG_W-1:0]  irq_en_wdata,
  input  logic              irq_clr_wr,
  input  logic [REG_W-1:0]  irq_clr_wdata,
  output logic [REG_W-1:0]  irq_en,
  output logic [REG_W-1:0]  irq_status,
  output logic [REG_W-1:0]  fifo_level,
  output logic              irq
);
  logic [CW-1:0] tx_count, rx_count;

  spi_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .push_data(tx_push_data),
    .pop(tx_pop), .pop_data(tx_pop_data), .count(tx_count)
  );

  spi_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .push_data(rx_push_data),
    .pop(rx_pop), .pop_data(rx_pop_data), .count(rx_count)
  );

  spi_fifo_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .rx_count(rx_count), .tx_count(tx_count),
    .xfer_done(xfer_done), .en_wr(irq_en_wr), .en_wdata(irq_en_wdata),
    .clr_wr(irq_clr_wr), .clr_wdata(irq_clr_wdata),
    .en_q(irq_en), .sta_q(irq_status), .irq(irq)
  );

  always_comb begin
    fifo_level = '0;
    fifo_level[LVL_RX_LSB +: CW] = rx_count;
    fifo_level[LVL_TX_LSB +: CW] = tx_count;
  end

  // R3: bits outside the two count fields stay zero
  p_level_pad_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_level & ~((REG_W'((1 << CW) - 1) << LVL_RX_LSB) |
                    (REG_W'((1 << CW) - 1) << LVL_TX_LSB))) == '0);
endmodule

// File: tb/spi_fifo_pair_tb.sv
module spi_fifo_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        tx_push, tx_pop, rx_push, rx_pop, tx_flush, rx_flush, xfer_done;
  logic [7:0]  tx_push_data, rx_push_data, tx_pop_data, rx_pop_data;
  logic        irq_en_wr, irq_clr_wr, irq;
  logic [31:0] irq_en_wdata, irq_clr_wdata, irq_en, irq_status, fifo_level;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] tx_sb[$];
  logic [7:0] rx_sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_pair u_dut (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_push_data(tx_push_data),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .xfer_done(xfer_done),
    .irq_en_wr(irq_en_wr), .irq_en_wdata(irq_en_wdata),
    .irq_clr_wr(irq_clr_wr), .irq_clr_wdata(irq_clr_wdata),
    .irq_en(irq_en), .irq_status(irq_status), .fifo_level(fifo_level), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_push = 1'b1; tx_push_data = b;
    tick();
    tx_push = 1'b0;
    if (tx_sb.size() < 64) tx_sb.push_back(b);
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_push = 1'b1; rx_push_data = b;
    tick();
    rx_push = 1'b0;
    if (rx_sb.size() < 64) rx_sb.push_back(b);
  endtask

  // monitor side: pop from design and compare with scoreboard front
  task automatic pop_tx(input string req);
    logic [7:0] exp;
    exp = (tx_sb.size() > 0) ? tx_sb.pop_front() : 8'h00;
    tx_pop = 1'b1;
    tick();
    tx_pop = 1'b0;
    check(req, {24'h0, tx_pop_data}, {24'h0, exp});
  endtask

  task automatic pop_rx(input string req);
    logic [7:0] exp;
    exp = (rx_sb.size() > 0) ? rx_sb.pop_front() : 8'h00;
    rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
    check(req, {24'h0, rx_pop_data}, {24'h0, exp});
  endtask

  task automatic clr(input logic [31:0] m);
    irq_clr_wr = 1'b1; irq_clr_wdata = m;
    tick();
    irq_clr_wr = 1'b0;
  endtask

  task automatic wr_en(input logic [31:0] m);
    irq_en_wr = 1'b1; irq_en_wdata = m;
    tick();
    irq_en_wr = 1'b0;
  endtask

  function automatic logic [31:0] lvl(input int rxc, input int txc);
    return (32'(txc) << 16) | 32'(rxc);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_flush = 0; rx_flush = 0; xfer_done = 0;
    irq_en_wr = 0; irq_clr_wr = 0;
    tx_push_data = 0; rx_push_data = 0; irq_en_wdata = 0; irq_clr_wdata = 0;
    repeat (3) tick();
    // R11 reset state
    check("R11 level", fifo_level, 32'h0);
    check("R11 status", irq_status, 32'h0);
    check("R11 enable", irq_en, 32'h0);
    check("R11 irq", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    tick();
    // R5: empty transmit queue raises bit 12 one edge after reset release
    check("R5 empty tx level", irq_status, 32'h0000_1000);

    // R5/R6: at 17 entries a cleared bit 12 stays low
    for (int i = 0; i < 17; i++) push_tx(8'(i * 7 + 3));
    clr(32'h0000_1000);
    check("R6 clear tx bit", irq_status[12], 1'b0);
    tick();
    check("R5 tx 17 stays low", irq_status[12], 1'b0);
    pop_tx("R2 tx order");
    check("R5 tx 16 not yet", irq_status[12], 1'b0);
    tick();
    check("R5 tx 16 sets", irq_status[12], 1'b1);

    // R1/R3: fill transmit queue
    for (int i = 0; i < 48; i++) push_tx(8'(i * 13 + 5));
    check("R1 R3 tx full level", fifo_level, lvl(0, 64));
    push_tx(8'hEE);
    check("R9 push full ignored", fifo_level, lvl(0, 64));
    for (int i = 0; i < 64; i++) pop_tx("R2 tx order");
    check("R1 tx drained", fifo_level, lvl(0, 0));
    pop_tx("R9 tx empty pop zero");
    check("R9 tx empty pop count", fifo_level, lvl(0, 0));

    // R4: receive threshold at 48
    for (int i = 0; i < 47; i++) push_rx(8'(i * 11 + 1));
    tick();
    check("R4 rx 47 low", irq_status[4], 1'b0);
    push_rx(8'hA5);
    check("R4 rx 48 not yet", irq_status[4], 1'b0);
    tick();
    check("R4 rx 48 sets", irq_status[4], 1'b1);
    check("R3 rx level", fifo_level, lvl(48, 0));
    // R6: clear while the level holds
    clr(32'h0000_0010);
    check("R6 rx clear drop", irq_status[4], 1'b0);
    tick();
    check("R6 rx re-set", irq_status[4], 1'b1);
    clr(32'h0000_0000);
    check("R6 zero write no effect", irq_status[4], 1'b1);
    for (int i = 0; i < 5; i++) pop_rx("R2 rx order");
    check("R2 rx level after pops", fifo_level, lvl(43, 0));

    // R8: flush beats a simultaneous push
    rx_flush = 1'b1; rx_push = 1'b1; rx_push_data = 8'h77;
    tick();
    rx_flush = 1'b0; rx_push = 1'b0;
    rx_sb.delete();
    check("R8 rx flush", fifo_level, lvl(0, 0));
    clr(32'h0000_0010);
    tick();
    check("R8 rx bit stays low", irq_status[4], 1'b0);
    pop_rx("R9 rx empty pop zero");

    for (int i = 0; i < 3; i++) push_tx(8'(i + 40));
    tx_flush = 1'b1; tx_pop = 1'b1;
    tick();
    tx_flush = 1'b0; tx_pop = 1'b0;
    tx_sb.delete();
    check("R8 tx flush", fifo_level, lvl(0, 0));
    check("R8 tx flush data zero", {24'h0, tx_pop_data}, 32'h0);

    // R10: enable register and combined line
    wr_en(32'hFFFF_FFFF);
    check("R10 enable bits", irq_en, 32'h0001_1010);
    check("R10 irq on tx level", {31'h0, irq}, 32'h1);
    wr_en(32'h0001_0000);
    clr(32'h0001_1010);
    tick();
    check("R10 tx level masked status", irq_status, 32'h0000_1000);
    check("R10 masked irq low", {31'h0, irq}, 32'h0);
    // R7: done pulse
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    check("R7 done sets", irq_status[16], 1'b1);
    check("R10 irq on done", {31'h0, irq}, 32'h1);
    xfer_done = 1'b1; irq_clr_wr = 1'b1; irq_clr_wdata = 32'h0001_0000;
    tick();
    xfer_done = 1'b0; irq_clr_wr = 1'b0;
    check("R7 pulse with clear keeps bit", irq_status[16], 1'b1);
    tick();
    check("R7 sticky", irq_status[16], 1'b1);
    clr(32'h0001_0000);
    check("R7 cleared", irq_status[16], 1'b0);
    check("R10 irq drops", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule